// File: doc/BRIEF.md
# DRAM Column-Phase Wait Sequencer

This block drives the column half of a DRAM access on behalf of a bus controller. After a start strobe it steps through a first column cycle (C1) and a closing column cycle (C2). Between those two it can place wait cycles. Programmed waits (PW) come from a 3-bit count. External waits (TW) are requested through an active-low wait pin. The waits lengthen the CAS-active window on a read. On a write they give the data time to settle before CAS is asserted. The row phase, refresh, address multiplexing and the data path stay with the surrounding controller.

The configuration is captured when an access is accepted. That configuration is: the wait-insertion enable, the programmed count, the global pin-wait enable and the per-pin enable. External waiting is honoured only when all three enables are set. In that case one programmed wait is always placed first, because the pin is examined at the end of the final PW cycle.

The pin passes through a two-flop synchronizer. A level change on the pin therefore reaches the sequence decision two clocks later. If the pin is released during the first TW cycle, exactly three TW cycles result.

Top module: `dcw_seq`

## Requirements
- R1: A synchronous active-high reset puts `phase_o` at idle (0), with `cas_o` and `done_o` low. This holds even in the middle of an access.
- R2: A high `start_i` while idle moves `phase_o` to C1 (code 1) on the next clock. `start_i` has no effect in any other phase.
- R3: With the wait-insertion enable clear, C2 (code 4) directly follows a single C1 cycle, whatever the count field and the wait pin hold.
- R4: With the wait-insertion enable set and pin wait not active, exactly N cycles of PW (code 2) come between C1 and C2, where N is the 3-bit count (0 to 7).
- R5: Pin wait is active only when the wait-insertion enable, the global pin-wait enable and the per-pin enable are all 1. When it is active and the count is 0, one PW cycle is still inserted.
- R6: When pin wait is active, the synchronized pin is sampled at the end of the final PW cycle. If the sampled value is low, the next phase is TW (code 3). If it is high, the next phase is C2.
- R7: TW repeats one cycle per clock while the synchronized pin is low, and moves to C2 once it is high. The synchronizer is two stages deep, so releasing the pin during the first TW cycle gives exactly three TW cycles.
- R8: On a read (`write_i` = 0 at acceptance), `cas_o` is high in every C1, PW, TW and C2 cycle.
- R9: On a write (`write_i` = 1 at acceptance), `cas_o` is high only in the C2 cycle.
- R10: `done_o` is high for exactly the one C2 cycle. The phase is idle on the following clock.
- R11: The configuration and direction inputs are captured when an access is accepted. Changing them during an access does not alter that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request a column sequence |
| write_i | input | 1 | 1 for a write access, 0 for a read |
| wait_en_i | input | 1 | Wait-insertion enable |
| wait_cnt_i | input | 3 | Programmed wait count |
| pin_wait_en_i | input | 1 | Global pin-wait enable |
| pin_port_en_i | input | 1 | Per-pin input enable for the wait pin |
| wait_n_i | input | 1 | External wait request, active low, asynchronous |
| phase_o | output | 3 | 0 idle, 1 C1, 2 PW, 3 TW, 4 C2 |
| cas_o | output | 1 | Column strobe, active high |
| done_o | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench targets these corner cases:

- **Zero count with pin wait active.** A design that omits the forced PW cycle would sample the pin in C1 and make the access one cycle short.
- **Pin held low with one enable missing.** A design that honours the pin in this case would stall in TW.
- **Pin released at the first TW cycle.** A synchronizer with the wrong depth shows up as a TW count other than three.
- **Changes during an access.** Mid-access changes to the count, the enable and the direction, and a start held high throughout, would expose missing capture or a re-triggered sequence.
- **Write-side CAS.** A design that asserts CAS early on writes would remove the data setup window.

// File: rtl/dcw_pkg.sv
package dcw_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_C1   = 3'd1,
        PH_PW   = 3'd2,
        PH_TW   = 3'd3,
        PH_C2   = 3'd4
    } phase_e;

endpackage

// File: rtl/dcw_sync.sv
// Multi-stage level synchronizer for the asynchronous wait pin.
module dcw_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = d_i;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RST_VAL}};
        else     chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dcw_cfg.sv
// Captures the wait configuration at acceptance and derives the effective
// programmed count and the pin-wait qualifier.
module dcw_cfg #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             en_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             glb_i,
    input  logic             port_i,
    output logic [CNT_W-1:0] eff_o,
    output logic             pin_o
);
    typedef struct packed {
        logic [CNT_W-1:0] eff;
        logic             pin;
    } cfg_t;

    cfg_t c_d;
    cfg_t c_q;

    always_comb begin
        c_d = c_q;
        if (load_i) begin
            c_d.pin = en_i & glb_i & port_i;
            if (!en_i)
                c_d.eff = '0;
            else if (c_d.pin && cnt_i == '0)
                c_d.eff = CNT_W'(1);
            else
                c_d.eff = cnt_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= '0;
        else     c_q <= c_d;
    end

    assign eff_o = c_q.eff;
    assign pin_o = c_q.pin;
endmodule

// File: rtl/dcw_fsm.sv
// Column phase state machine with registered strobe and done outputs.
module dcw_fsm
    import dcw_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             write_i,
    input  logic [CNT_W-1:0] eff_i,
    input  logic             pin_i,
    input  logic             wait_hi_i,
    output phase_e           phase_o,
    output logic             cas_o,
    output logic             done_o,
    output logic             accept_o
);
    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] left;
        logic             wr;
        logic             cas;
        logic             done;
    } st_t;

    st_t s_d;
    st_t s_q;

    assign accept_o = (s_q.ph == PH_IDLE) && start_i;

    always_comb begin
        s_d = s_q;
        case (s_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    s_d.ph = PH_C1;
                    s_d.wr = write_i;
                end
            end
            PH_C1: begin
                if (eff_i == '0) begin
                    s_d.ph = PH_C2;
                end else begin
                    s_d.ph   = PH_PW;
                    s_d.left = eff_i - CNT_W'(1);
                end
            end
            PH_PW: begin
                if (s_q.left != '0)
                    s_d.left = s_q.left - CNT_W'(1);
                else if (pin_i && !wait_hi_i)
                    s_d.ph = PH_TW;
                else
                    s_d.ph = PH_C2;
            end
            PH_TW: begin
                if (wait_hi_i) s_d.ph = PH_C2;
            end
            PH_C2:   s_d.ph = PH_IDLE;
            default: s_d.ph = PH_IDLE;
        endcase
        s_d.cas  = (s_d.ph == PH_C2) ||
                   (!s_d.wr && (s_d.ph inside {PH_C1, PH_PW, PH_TW}));
        s_d.done = (s_d.ph == PH_C2);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '{ph: PH_IDLE, left: '0, wr: 1'b0, cas: 1'b0, done: 1'b0};
        else     s_q <= s_d;
    end

    assign phase_o = s_q.ph;
    assign cas_o   = s_q.cas;
    assign done_o  = s_q.done;
endmodule

// File: rtl/dcw_seq.sv
module dcw_seq #(
    parameter int CNT_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             write_i,
    input  logic             wait_en_i,
    input  logic [CNT_W-1:0] wait_cnt_i,
    input  logic             pin_wait_en_i,
    input  logic             pin_port_en_i,
    input  logic             wait_n_i,
    output logic [2:0]       phase_o,
    output logic             cas_o,
    output logic             done_o
);
    import dcw_pkg::*;

    logic             accept;
    logic             wait_hi;
    logic [CNT_W-1:0] eff;
    logic             pin_act;
    phase_e           ph;

    dcw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (wait_n_i),
        .q_o (wait_hi)
    );

    dcw_cfg #(.CNT_W(CNT_W)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load_i (accept),
        .en_i   (wait_en_i),
        .cnt_i  (wait_cnt_i),
        .glb_i  (pin_wait_en_i),
        .port_i (pin_port_en_i),
        .eff_o  (eff),
        .pin_o  (pin_act)
    );

    dcw_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .write_i   (write_i),
        .eff_i     (eff),
        .pin_i     (pin_act),
        .wait_hi_i (wait_hi),
        .phase_o   (ph),
        .cas_o     (cas_o),
        .done_o    (done_o),
        .accept_o  (accept)
    );

    assign phase_o = ph;
endmodule

// File: rtl/dcw_checker.sv
module dcw_checker (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       write_i,
    input logic       wait_en_i,
    input logic [2:0] phase_o,
    input logic       cas_o,
    input logic       done_o
);
    import dcw_pkg::*;

    logic wr_l;
    logic en_l;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_l <= 1'b0;
            en_l <= 1'b0;
        end else if (phase_o == PH_IDLE && start_i) begin
            wr_l <= write_i;
            en_l <= wait_en_i;
        end
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (phase_o == PH_IDLE) |-> (!cas_o && !done_o));

    a_r2_enter_c1: assert property (@(posedge clk) disable iff (rst)
        (phase_o == PH_IDLE && start_i) |=> (phase_o == PH_C1));

    a_r2_busy_ignore: assert property (@(posedge clk) disable iff (rst)
        (phase_o != PH_IDLE) |=> (phase_o != PH_C1));

    a_r3_direct_c2: assert property (@(posedge clk) disable iff (rst)
        (phase_o == PH_C1 && !en_l) |=> (phase_o == PH_C2));

    a_r8_read_cas: assert property (@(posedge clk) disable iff (rst)
        (!wr_l && phase_o != PH_IDLE) |-> cas_o);

    a_r9_write_cas: assert property (@(posedge clk) disable iff (rst)
        (wr_l && (phase_o == PH_C1 || phase_o == PH_PW || phase_o == PH_TW)) |-> !cas_o);

    a_r10_done_in_c2: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (phase_o == PH_C2));

    a_r10_single_done: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r10_back_idle: assert property (@(posedge clk) disable iff (rst)
        (phase_o == PH_C2) |=> (phase_o == PH_IDLE));
endmodule

bind dcw_seq dcw_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .write_i   (write_i),
    .wait_en_i (wait_en_i),
    .phase_o   (phase_o),
    .cas_o     (cas_o),
    .done_o    (done_o)
);

// File: tb/dcw_seq_test.sv
`timescale 1ns/1ps
module dcw_seq_test;
    localparam int CLK_NS = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       write_i = 1'b0;
    logic       wait_en_i = 1'b0;
    logic [2:0] wait_cnt_i = 3'd0;
    logic       pin_wait_en_i = 1'b0;
    logic       pin_port_en_i = 1'b0;
    logic       wait_n_i = 1'b1;
    logic [2:0] phase_o;
    logic       cas_o;
    logic       done_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    dcw_seq uut (
        .clk(clk), .rst(rst), .start_i(start_i), .write_i(write_i),
        .wait_en_i(wait_en_i), .wait_cnt_i(wait_cnt_i),
        .pin_wait_en_i(pin_wait_en_i), .pin_port_en_i(pin_port_en_i),
        .wait_n_i(wait_n_i), .phase_o(phase_o), .cas_o(cas_o), .done_o(done_o)
    );

    // Reference model built from the requirements (phase codes 0..4).
    logic [2:0] m_ph = 3'd0;
    int         m_left = 0;
    int         m_eff = 0;
    bit         m_pin = 1'b0;
    bit         m_wr = 1'b0;
    logic       m_s1 = 1'b1;
    logic       m_s2 = 1'b1;

    function automatic int eff_count(bit en, int cnt, bit pin);
        if (!en) return 0;
        if (pin && cnt == 0) return 1;
        return cnt;
    endfunction

    function automatic bit exp_cas(logic [2:0] ph, bit wr);
        if (ph == 3'd4) return 1'b1;
        if (ph == 3'd0) return 1'b0;
        return !wr;
    endfunction

    always @(posedge clk) begin
        m_s1 <= rst ? 1'b1 : wait_n_i;
        m_s2 <= rst ? 1'b1 : m_s1;
        if (rst) begin
            m_ph <= 3'd0;
        end else begin
            case (m_ph)
                3'd0: if (start_i) begin
                    m_ph  <= 3'd1;
                    m_wr  <= write_i;
                    m_pin <= wait_en_i && pin_wait_en_i && pin_port_en_i;
                    m_eff <= eff_count(wait_en_i, int'(wait_cnt_i),
                                       wait_en_i && pin_wait_en_i && pin_port_en_i);
                end
                3'd1: begin
                    if (m_eff == 0) m_ph <= 3'd4;
                    else begin m_ph <= 3'd2; m_left <= m_eff; end
                end
                3'd2: begin
                    if (m_left > 1) m_left <= m_left - 1;
                    else if (m_pin && !m_s2) m_ph <= 3'd3;
                    else m_ph <= 3'd4;
                end
                3'd3: if (m_s2) m_ph <= 3'd4;
                default: m_ph <= 3'd0;
            endcase
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (!rst && !finished) begin
            checks++;
            if (phase_o !== m_ph) begin
                fails++;
                case (m_ph)
                    3'd1:    $display("FAIL R2 phase act=%0d exp=%0d", phase_o, m_ph);
                    3'd2:    $display("FAIL R4 phase act=%0d exp=%0d", phase_o, m_ph);
                    3'd3:    $display("FAIL R7 phase act=%0d exp=%0d", phase_o, m_ph);
                    3'd4:    $display("FAIL R3 phase act=%0d exp=%0d", phase_o, m_ph);
                    default: $display("FAIL R10 phase act=%0d exp=%0d", phase_o, m_ph);
                endcase
            end
            if (cas_o !== exp_cas(m_ph, m_wr)) begin
                fails++;
                if (m_wr) $display("FAIL R9 cas act=%0b exp=%0b", cas_o, exp_cas(m_ph, m_wr));
                else      $display("FAIL R8 cas act=%0b exp=%0b", cas_o, exp_cas(m_ph, m_wr));
            end
            if (done_o !== (m_ph == 3'd4)) begin
                fails++;
                $display("FAIL R10 done act=%0b exp=%0b", done_o, m_ph == 3'd4);
            end
        end
    end

    task automatic check_eq(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // Directed access: returns the number of non-idle cycles seen.
    task automatic access(bit wr, bit en, int cnt, bit glb, bit port,
                          bit pin_low, bit release_tw, bit mutate, bit hold_start,
                          output int len, output int tw);
        write_i = wr; wait_en_i = en; wait_cnt_i = 3'(cnt);
        pin_wait_en_i = glb; pin_port_en_i = port;
        wait_n_i = !pin_low;
        repeat (3) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        if (!hold_start) start_i = 1'b0;
        if (mutate) begin
            wait_cnt_i = 3'd7; wait_en_i = !en; write_i = !wr;
            pin_wait_en_i = !glb;
        end
        len = 0; tw = 0;
        for (int i = 0; i < 60; i++) begin
            if (phase_o != 3'd0) len++;
            if (phase_o == 3'd3) begin
                tw++;
                if (release_tw) wait_n_i = 1'b1;
            end
            if (done_o) begin
                start_i = 1'b0;
                break;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        wait_n_i = 1'b1;
        @(negedge clk);
        check_eq("R10 idle after done", int'(phase_o), 0);
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int len;
        int tw;
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0421);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check_eq("R1 phase", int'(phase_o), 0);
        check_eq("R1 cas", int'(cas_o), 0);
        check_eq("R1 done", int'(done_o), 0);

        // R3: enable clear, pin low and enabled, count ignored
        access(0, 0, 5, 1, 1, 1, 0, 0, 0, len, tw);
        check_eq("R3 length", len, 2);
        // R4: programmed counts
        access(0, 1, 0, 0, 0, 0, 0, 0, 0, len, tw);
        check_eq("R4 count0 length", len, 2);
        access(1, 1, 7, 0, 0, 0, 0, 0, 0, len, tw);
        check_eq("R4 count7 length", len, 9);
        access(0, 1, 3, 1, 0, 1, 0, 0, 0, len, tw);
        check_eq("R4 count3 pin off length", len, 5);
        // R5: forced PW with zero count, pin high
        access(0, 1, 0, 1, 1, 0, 0, 0, 0, len, tw);
        check_eq("R5 forced PW length", len, 3);
        // R5: per-pin enable clear, pin held low: no TW
        access(1, 1, 2, 1, 0, 1, 0, 0, 0, len, tw);
        check_eq("R5 port off no TW", tw, 0);
        // R6 / R7: pin low at sampling, released at first TW
        access(0, 1, 0, 1, 1, 1, 1, 0, 0, len, tw);
        check_eq("R6 TW entered length", len, 6);
        check_eq("R7 TW count", tw, 3);
        access(1, 1, 4, 1, 1, 1, 1, 0, 0, len, tw);
        check_eq("R7 TW count after PW", tw, 3);
        check_eq("R7 length", len, 9);
        // R11: inputs change after acceptance
        access(0, 1, 2, 0, 1, 0, 0, 1, 0, len, tw);
        check_eq("R11 captured length", len, 4);
        // R2: start held through the access
        access(1, 1, 1, 0, 0, 0, 0, 0, 1, len, tw);
        check_eq("R2 held start length", len, 3);

        // R1: reset in the middle of an access
        write_i = 0; wait_en_i = 1; wait_cnt_i = 3'd6; start_i = 1;
        @(negedge clk); start_i = 0;
        @(negedge clk); @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_eq("R1 mid reset phase", int'(phase_o), 0);
        check_eq("R1 mid reset cas", int'(cas_o), 0);

        // Random stimulus checked cycle by cycle against the model
        for (int c = 0; c < 4000; c++) begin
            start_i       = ($urandom_range(0, 3) == 0);
            write_i       = $urandom_range(0, 1);
            wait_en_i     = ($urandom_range(0, 3) != 0);
            wait_cnt_i    = 3'($urandom_range(0, 7));
            pin_wait_en_i = ($urandom_range(0, 3) != 0);
            pin_port_en_i = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 3) == 0) wait_n_i = ~wait_n_i;
            @(negedge clk);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule